// File: doc/BRIEF.md
# Flash Control and Erase Sequencer

This block is the register-side controller that sits between a small 8-bit processor core and its on-chip flash. Software uses it to pick a flash bank, give a page number, enable mass erase and program writes, and issue erase commands. An erase starts only when software writes a fixed command byte and has first made the matching arming writes. Each arming write is good for one erase. An erase cycle stays open until software writes 0x00 to the command register.

The block also maps addresses in both directions. It turns the upper 32 KB window of the 16-bit code space into a banked flash address. It also sends external-data writes either to flash or to XRAM, depending on the program-write enable. A request/done handshake takes the place of the flash array. `erase_busy_o` stays high from the start of an erase until the array reports completion.

Register map (select on `reg_addr_i`): 0 = bank select in bits [2:0]; 1 = page address in bits [5:0]; 2 = control, where bit 0 is program-write enable and bit 1 is mass-erase enable; 3 = erase command on write, and erase status on read; 4 = error, where bit 0 is the sticky dropped-write flag.

Top module: `flash_ctl`

## Requirements
- R1: When the sequencer is idle and the page erase is armed, writing 0x55 to register 3 starts a page erase. The cycle after that write, `flash_erase_req_o` is high for exactly one cycle, `flash_erase_mass_o` is 0, `flash_erase_page_o` is {bank[0], pgadr[5:0]}, and `erase_busy_o` is high.
- R2: A write to register 1 arms the page erase. Each page erase that starts uses up the arming, so a later 0x55 with no new write to register 1 has no effect.
- R3: Writing 0xAA to register 3 starts a mass erase (`flash_erase_mass_o` = 1) only when all three of these hold: control bit 1 is 1, `dbg_en_i` is 1, and register 2 has been written since the last mass erase began.
- R4: In the idle state, a write to register 3 of any value other than 0x55 or 0xAA starts nothing and leaves the arming unchanged.
- R5: Register 3 reads back 0 when idle, 1 while busy, and 2 once `flash_done_i` has arrived. While busy or done, every command byte is ignored, with one exception: in the done state a write of 0x00 returns the sequencer to idle.
- R6: The bank-select register reads back 0 after any erase starts.
- R7: When `cpu_addr_i[15]` is 1, `code_addr_o` is {bank[2:0], cpu_addr_i[14:0]}. Otherwise it is cpu_addr_i with the upper bits set to zero.
- R8: On an external-data write, `flash_we_o` is asserted if control bit 0 is set, and `xram_we_o` is asserted if it is clear. Reset selects XRAM.
- R9: While `int_en_i` is 1, a write to register 2 leaves control bit 0 unchanged but still updates bit 1.
- R10: An external-data write to flash while an erase is busy is dropped, so neither write enable rises. It sets error bit 0, which stays set until software writes register 4 with bit 0 = 1.
- R11: After reset, every register reads back 0x00, and each register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| int_en_i | input | 1 | Global interrupt enable of the core |
| dbg_en_i | input | 1 | Debug port enabled |
| cpu_addr_i | input | 16 | Code-space fetch address |
| code_addr_o | output | 18 | Mapped flash address |
| xwr_i | input | 1 | External-data write strobe |
| xwr_addr_i | input | 16 | Data pointer of the external write |
| xwr_data_i | input | 8 | External write data |
| flash_we_o | output | 1 | Byte write to flash |
| xram_we_o | output | 1 | Byte write to XRAM |
| wr_addr_o | output | 16 | Write address to flash or XRAM |
| wr_data_o | output | 8 | Write data to flash or XRAM |
| flash_erase_req_o | output | 1 | One-cycle erase request |
| flash_erase_mass_o | output | 1 | 1 = mass erase, 0 = page erase |
| flash_erase_page_o | output | 7 | Page number to erase |
| flash_done_i | input | 1 | Erase finished by the array |
| erase_busy_o | output | 1 | Erase in progress |

## Verification
The hardest case to reach is an arming flag that persists across a refused command. The bench first rewrites the page address while a cycle waits in the done state. It then sends 0x55, which must be ignored there. Only after 0x00 closes the cycle may a second 0x55 start a new erase. Mass erase is approached the same way: it is first refused with the debug port disabled, and is then shown to start without any new arming write once the port is enabled. Dropped flash writes are produced by holding `flash_done_i` back, so that an external write lands inside the busy window.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } erase_st_e;

  localparam logic [2:0] RA_BANK  = 3'd0;
  localparam logic [2:0] RA_PGADR = 3'd1;
  localparam logic [2:0] RA_CTRL  = 3'd2;
  localparam logic [2:0] RA_ERASE = 3'd3;
  localparam logic [2:0] RA_ERR   = 3'd4;

  localparam logic [7:0] CMD_PAGE  = 8'h55;
  localparam logic [7:0] CMD_MASS  = 8'hAA;
  localparam logic [7:0] CMD_CLOSE = 8'h00;
endpackage

// File: rtl/flash_regs.sv
module flash_regs
  import flash_ctl_pkg::*;
#(
  parameter int DW     = 8,
  parameter int BANK_W = 3,
  parameter int PG_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic              int_en_i,
  input  logic              start_page_i,
  input  logic              start_mass_i,
  input  logic              wr_drop_i,
  input  logic [1:0]        status_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [PG_W-1:0]   pgadr_o,
  output logic              pwe_o,
  output logic              meen_o,
  output logic              page_armed_o,
  output logic              mass_armed_o,
  output logic [DW-1:0]     rdata_o
);
  logic [BANK_W-1:0] bank_q;
  logic [PG_W-1:0]   pgadr_q;
  logic              pwe_q, meen_q, page_arm_q, mass_arm_q, err_q;
  logic              wr_bank, wr_pg, wr_ctrl, wr_err;

  assign wr_bank = reg_we_i && (reg_addr_i == RA_BANK);
  assign wr_pg   = reg_we_i && (reg_addr_i == RA_PGADR);
  assign wr_ctrl = reg_we_i && (reg_addr_i == RA_CTRL);
  assign wr_err  = reg_we_i && (reg_addr_i == RA_ERR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q     <= '0;
      pgadr_q    <= '0;
      pwe_q      <= 1'b0;
      meen_q     <= 1'b0;
      page_arm_q <= 1'b0;
      mass_arm_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (start_page_i || start_mass_i) bank_q <= '0;
      else if (wr_bank)                 bank_q <= reg_wdata_i[BANK_W-1:0];

      if (wr_pg) pgadr_q <= reg_wdata_i[PG_W-1:0];

      if (wr_ctrl) begin
        meen_q <= reg_wdata_i[1];
        if (!int_en_i) pwe_q <= reg_wdata_i[0];
      end

      if (start_page_i) page_arm_q <= 1'b0;
      else if (wr_pg)   page_arm_q <= 1'b1;

      if (start_mass_i) mass_arm_q <= 1'b0;
      else if (wr_ctrl) mass_arm_q <= 1'b1;

      if (wr_drop_i)                   err_q <= 1'b1;
      else if (wr_err && reg_wdata_i[0]) err_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_addr_i)
      RA_BANK:  rdata_o = {{(DW-BANK_W){1'b0}}, bank_q};
      RA_PGADR: rdata_o = {{(DW-PG_W){1'b0}}, pgadr_q};
      RA_CTRL:  rdata_o = {{(DW-2){1'b0}}, meen_q, pwe_q};
      RA_ERASE: rdata_o = {{(DW-2){1'b0}}, status_i};
      RA_ERR:   rdata_o = {{(DW-1){1'b0}}, err_q};
      default:  rdata_o = '0;
    endcase
  end

  assign bank_o       = bank_q;
  assign pgadr_o      = pgadr_q;
  assign pwe_o        = pwe_q;
  assign meen_o       = meen_q;
  assign page_armed_o = page_arm_q;
  assign mass_armed_o = mass_arm_q;

  assert_bank_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_page_i || start_mass_i) |=> (bank_q == '0));

  assert_pwe_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && int_en_i) |=> $stable(pwe_q));

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(wr_err && reg_wdata_i[0])) |=> err_q);

  assert_page_arm_used_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_page_i |=> !page_arm_q);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_ctl_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PG_W   = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_we_i,
  input  logic [DW-1:0]   cmd_data_i,
  input  logic            page_armed_i,
  input  logic            mass_armed_i,
  input  logic            meen_i,
  input  logic            dbg_en_i,
  input  logic            bank_lsb_i,
  input  logic [PG_W-1:0] pgadr_i,
  input  logic            flash_done_i,
  output logic            start_page_o,
  output logic            start_mass_o,
  output logic            req_o,
  output logic            mass_o,
  output logic [PG_W:0]   page_o,
  output logic            busy_o,
  output logic [1:0]      status_o
);
  erase_st_e     state_q, state_d;
  logic          req_q, mass_q;
  logic [PG_W:0] page_q;
  logic          idle;

  assign idle         = (state_q == ST_IDLE);
  assign start_page_o = idle && cmd_we_i && (cmd_data_i == DW'(CMD_PAGE)) && page_armed_i;
  assign start_mass_o = idle && cmd_we_i && (cmd_data_i == DW'(CMD_MASS))
                        && meen_i && dbg_en_i && mass_armed_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_page_o || start_mass_o) state_d = ST_BUSY;
      ST_BUSY: if (flash_done_i) state_d = ST_DONE;
      ST_DONE: if (cmd_we_i && (cmd_data_i == DW'(CMD_CLOSE))) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      mass_q  <= 1'b0;
      page_q  <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= start_page_o || start_mass_o;
      if (start_page_o || start_mass_o) begin
        mass_q <= start_mass_o;
        page_q <= {bank_lsb_i, pgadr_i};
      end
    end
  end

  assign req_o    = req_q;
  assign mass_o   = mass_q;
  assign page_o   = page_q;
  assign busy_o   = (state_q == ST_BUSY);
  assign status_o = state_q;

  assert_req_only_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> !req_q);

  assert_req_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);

  assert_close_needs_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !(cmd_we_i && cmd_data_i == '0)) |=> (state_q == ST_DONE));

  assert_mass_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_mass_o |-> (dbg_en_i && meen_i && mass_armed_i));

  assert_unarmed_page_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !page_armed_i && !start_mass_o) |=> !req_q);
endmodule

// File: rtl/flash_addr_map.sv
module flash_addr_map #(
  parameter int AW     = 16,
  parameter int BANK_W = 3,
  localparam int FA_W  = BANK_W + AW - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     cpu_addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              xwr_i,
  input  logic              pwe_i,
  input  logic              busy_i,
  output logic [FA_W-1:0]   code_addr_o,
  output logic              flash_we_o,
  output logic              xram_we_o,
  output logic              wr_drop_o
);
  assign code_addr_o = cpu_addr_i[AW-1] ? {bank_i, cpu_addr_i[AW-2:0]}
                                        : {{(BANK_W-1){1'b0}}, cpu_addr_i};
  assign flash_we_o  = xwr_i && pwe_i && !busy_i;
  assign xram_we_o   = xwr_i && !pwe_i;
  assign wr_drop_o   = xwr_i && pwe_i && busy_i;

  assert_low_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_addr_i[AW-1] |-> (code_addr_o[FA_W-1:AW] == '0));

  assert_one_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flash_we_o && xram_we_o));

  assert_no_flash_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !flash_we_o);
endmodule

// File: rtl/flash_ctl.sv
module flash_ctl
  import flash_ctl_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 16,
  parameter int BANK_W = 3,
  parameter int PG_W   = 6,
  localparam int FA_W  = BANK_W + AW - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic            int_en_i,
  input  logic            dbg_en_i,
  input  logic [AW-1:0]   cpu_addr_i,
  output logic [FA_W-1:0] code_addr_o,
  input  logic            xwr_i,
  input  logic [AW-1:0]   xwr_addr_i,
  input  logic [DW-1:0]   xwr_data_i,
  output logic            flash_we_o,
  output logic            xram_we_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [DW-1:0]   wr_data_o,
  output logic            flash_erase_req_o,
  output logic            flash_erase_mass_o,
  output logic [PG_W:0]   flash_erase_page_o,
  input  logic            flash_done_i,
  output logic            erase_busy_o
);
  logic [BANK_W-1:0] bank;
  logic [PG_W-1:0]   pgadr;
  logic              pwe, meen, page_armed, mass_armed;
  logic              start_page, start_mass, wr_drop, busy;
  logic [1:0]        status;

  flash_regs #(.DW(DW), .BANK_W(BANK_W), .PG_W(PG_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .int_en_i,
    .start_page_i(start_page), .start_mass_i(start_mass), .wr_drop_i(wr_drop),
    .status_i(status), .bank_o(bank), .pgadr_o(pgadr), .pwe_o(pwe), .meen_o(meen),
    .page_armed_o(page_armed), .mass_armed_o(mass_armed), .rdata_o(reg_rdata_o)
  );

  flash_erase_seq #(.DW(DW), .PG_W(PG_W)) u_seq (
    .clk_i, .rst_ni,
    .cmd_we_i(reg_we_i && (reg_addr_i == RA_ERASE)), .cmd_data_i(reg_wdata_i),
    .page_armed_i(page_armed), .mass_armed_i(mass_armed), .meen_i(meen),
    .dbg_en_i, .bank_lsb_i(bank[0]), .pgadr_i(pgadr), .flash_done_i,
    .start_page_o(start_page), .start_mass_o(start_mass),
    .req_o(flash_erase_req_o), .mass_o(flash_erase_mass_o), .page_o(flash_erase_page_o),
    .busy_o(busy), .status_o(status)
  );

  flash_addr_map #(.AW(AW), .BANK_W(BANK_W)) u_map (
    .clk_i, .rst_ni, .cpu_addr_i, .bank_i(bank), .xwr_i, .pwe_i(pwe), .busy_i(busy),
    .code_addr_o, .flash_we_o, .xram_we_o, .wr_drop_o(wr_drop)
  );

  assign wr_addr_o    = xwr_addr_i;
  assign wr_data_o    = xwr_data_i;
  assign erase_busy_o = busy;
endmodule

// File: tb/sim_flash_ctl.sv
`timescale 1ns/1ps
module sim_flash_ctl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0, int_en = 1'b0, dbg_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic [15:0] cpu_addr = '0, xwr_addr = '0, wr_addr;
  logic [17:0] code_addr;
  logic        xwr = 1'b0, flash_we, xram_we, req, mass, done = 1'b0, busy;
  logic [7:0]  xwr_data = '0, wr_data;
  logic [6:0]  page;
  int n_chk = 0, n_fail = 0;
  bit  finished = 0;

  always #10 clk = ~clk;

  flash_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .int_en_i(int_en), .dbg_en_i(dbg_en),
    .cpu_addr_i(cpu_addr), .code_addr_o(code_addr), .xwr_i(xwr), .xwr_addr_i(xwr_addr),
    .xwr_data_i(xwr_data), .flash_we_o(flash_we), .xram_we_o(xram_we), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .flash_erase_req_o(req), .flash_erase_mass_o(mass),
    .flash_erase_page_o(page), .flash_done_i(done), .erase_busy_o(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse_done;
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic close_cycle;
    pulse_done();
    wr(3'd3, 8'h00);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) rd_chk("R11 reset reg", 3'(a), 0);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset req", req, 0);
  endtask

  task automatic t_page;
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h2A);
    rd_chk("R11 bank readback", 3'd0, 3);
    rd_chk("R11 pgadr readback", 3'd1, 8'h2A);
    wr(3'd3, 8'h55);
    chk("R1 req", req, 1);
    chk("R1 mass flag", mass, 0);
    chk("R1 page", page, 7'h6A);
    chk("R1 busy", busy, 1);
    rd_chk("R5 status busy", 3'd3, 1);
    rd_chk("R6 bank cleared", 3'd0, 0);
    @(negedge clk);
    chk("R1 req one cycle", req, 0);
    wr(3'd3, 8'h00);
    rd_chk("R5 zero ignored while busy", 3'd3, 1);
    pulse_done();
    chk("R5 busy drops on done", busy, 0);
    rd_chk("R5 status done", 3'd3, 2);
    wr(3'd1, 8'h05);
    wr(3'd3, 8'h55);
    chk("R5 cmd ignored in done", req, 0);
    rd_chk("R5 still done", 3'd3, 2);
    wr(3'd3, 8'h00);
    rd_chk("R5 closed to idle", 3'd3, 0);
    wr(3'd3, 8'h55);
    chk("R2 arming kept across done", req, 1);
    chk("R2 page second", page, 7'h05);
    close_cycle();
    wr(3'd3, 8'h55);
    chk("R2 arming used up", req, 0);
    rd_chk("R2 still idle", 3'd3, 0);
  endtask

  task automatic t_bad_pattern;
    wr(3'd1, 8'h01);
    wr(3'd3, 8'h12);
    chk("R4 0x12 no req", req, 0);
    wr(3'd3, 8'hFF);
    chk("R4 0xFF no req", req, 0);
    rd_chk("R4 idle", 3'd3, 0);
    wr(3'd3, 8'h55);
    chk("R4 arming intact", req, 1);
    chk("R4 page", page, 7'h01);
    close_cycle();
  endtask

  task automatic t_mass;
    dbg_en = 1'b0;
    wr(3'd2, 8'h02);
    wr(3'd3, 8'hAA);
    chk("R3 no debug no erase", req, 0);
    dbg_en = 1'b1;
    wr(3'd3, 8'hAA);
    chk("R3 mass req", req, 1);
    chk("R3 mass flag", mass, 1);
    close_cycle();
    wr(3'd3, 8'hAA);
    chk("R3 mass arming used", req, 0);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'hAA);
    chk("R3 enable clear no erase", req, 0);
    wr(3'd2, 8'h02);
    wr(3'd3, 8'hAA);
    chk("R3 rearmed mass", req, 1);
    close_cycle();
    wr(3'd2, 8'h00);
  endtask

  task automatic t_addr;
    wr(3'd0, 8'h05);
    cpu_addr = 16'h9234; #1;
    chk("R7 upper window", code_addr, 18'h29234);
    cpu_addr = 16'hFFFF; #1;
    chk("R7 window top", code_addr, 18'h2FFFF);
    cpu_addr = 16'h1234; #1;
    chk("R7 lower direct", code_addr, 18'h01234);
  endtask

  task automatic xw_chk(input string tag, input int exp_f, input int exp_x);
    @(negedge clk); xwr = 1'b1; xwr_addr = 16'hC0DE; xwr_data = 8'h5A; #1;
    chk({tag, " flash_we"}, flash_we, exp_f);
    chk({tag, " xram_we"}, xram_we, exp_x);
    @(negedge clk); xwr = 1'b0;
  endtask

  task automatic t_pwe;
    int_en = 1'b0;
    xw_chk("R8 default xram", 0, 1);
    wr(3'd2, 8'h01);
    xw_chk("R8 pwe flash", 1, 0);
    chk("R8 addr pass", wr_addr, 16'hC0DE);
    int_en = 1'b1;
    wr(3'd2, 8'h00);
    rd_chk("R9 pwe locked", 3'd2, 1);
    wr(3'd2, 8'h02);
    rd_chk("R9 meen still written", 3'd2, 3);
    int_en = 1'b0;
    wr(3'd2, 8'h00);
    rd_chk("R9 pwe cleared", 3'd2, 0);
  endtask

  task automatic t_drop;
    wr(3'd2, 8'h01);
    wr(3'd1, 8'h03);
    wr(3'd3, 8'h55);
    xw_chk("R10 drop while busy", 0, 0);
    rd_chk("R10 err set", 3'd4, 1);
    close_cycle();
    rd_chk("R10 err sticky", 3'd4, 1);
    wr(3'd4, 8'h00);
    rd_chk("R10 err needs bit0", 3'd4, 1);
    wr(3'd4, 8'h01);
    rd_chk("R10 err cleared", 3'd4, 0);
    wr(3'd2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page();
    t_bad_pattern();
    t_mass();
    t_addr();
    t_pwe();
    t_drop();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule